// File: doc/BRIEF.md
# Carrier Detect and Handshake Line Timer

This block drives the three handshake lines of a half-duplex modem: ready-for-sending toward the local terminal, carrier detect for the receive path, and a clamp enable that forces received data to binary ONE. It takes the local request-to-send, a one-cycle training-complete pulse, two flags from a received-level comparator (level above the ON threshold and level above the lower OFF threshold), an initial-handshake-done flag, and a one-millisecond tick. Level measurement and the training sequence are done elsewhere.

Carrier detect turns on first through training. After the initial handshake, a dropout is bridged by two millisecond timers: an OFF timer that clears carrier detect once the level has stayed below the OFF threshold for a programmed time, and an ON timer that sets it again once the level has stayed above the ON threshold for a programmed time. The gap between the two thresholds gives the hysteresis. While request-to-send is on, and for a programmed hold time after it drops, the receive side is clamped and carrier detect is forced off. The three delays sit in a small configuration register bank. Its reset values are 40 ms for OFF, 100 ms for ON and 150 ms for the clamp hold, which keeps each delay inside its required window. Request-to-send, both level flags and the handshake flag each pass through a two-flop synchronizer.

Top module: `line_handshake_timer`

## Requirements
- R1: After reset, rfs_o, cd_o and clamp_o are 0. The configuration resets to OFF delay 40, ON delay 100 and clamp hold 150 millisecond ticks.
- R2: rfs_o stays 0 until train_done_i pulses while the synchronized request-to-send is on. From then on, rfs_o follows both edges of rts_i, settling within 4 clock cycles.
- R3: While the synchronized request-to-send is on, clamp_o is 1 and cd_o is 0. A train_done_i pulse in that state does not set cd_o.
- R4: When request-to-send goes off, clamp_o stays 1 and cd_o stays 0 until the clamp-hold count of millisecond ticks has elapsed. A hold of 0 releases the clamp within 4 cycles of the drop.
- R5: A train_done_i pulse while not clamped sets cd_o to 1, whether or not the handshake flag is set.
- R6: While cd_o is 1 and lvl_above_off_i is 0, cd_o falls after exactly the OFF-delay count of ticks, and not after one tick fewer.
- R7: If lvl_above_off_i returns to 1 before the OFF delay expires, the count is discarded and cd_o stays 1. A later dropout needs the full count again.
- R8: With hs_done_i at 1, cd_o at 0 and no clamp, cd_o rises after exactly the ON-delay count of ticks with lvl_above_on_i at 1. A level between the thresholds (above OFF, below ON) never raises it and restarts the count.
- R9: While hs_done_i is 0, the received level alone never raises cd_o.
- R10: A write with cfg_we_i at 1 stores cfg_data_i into the OFF delay (cfg_sel_i = 0), the ON delay (1) or the clamp hold (2). The new value governs the next count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| rts_i | input | 1 | Local request-to-send (asynchronous) |
| train_done_i | input | 1 | One-cycle pulse when a training sequence completes |
| lvl_above_on_i | input | 1 | Received level is above the ON threshold (asynchronous) |
| lvl_above_off_i | input | 1 | Received level is above the OFF threshold (asynchronous) |
| hs_done_i | input | 1 | Initial handshake has completed (asynchronous) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Target delay: 0 OFF, 1 ON, 2 clamp hold |
| cfg_data_i | input | 8 | Delay value in millisecond ticks |
| rfs_o | output | 1 | Ready-for-sending |
| cd_o | output | 1 | Carrier detect |
| clamp_o | output | 1 | Force received data to ONE |

## Verification
The ON timer can reach its count on the same clock edge at which the synchronized request-to-send rises. That puts the carrier-detect set and the clamp into the same next-state computation. The bench brings the ON timer to one tick short, raises request-to-send one cycle ahead of the final tick so that both land on one edge, and then watches cd_o every cycle for several cycles. The case passes only if cd_o never rises and clamp_o holds. The same ordering is checked for a training pulse that arrives while request-to-send is on.

// File: rtl/lht_pkg.sv
package lht_pkg;
    localparam int CNT_W = 8;

    localparam logic [CNT_W-1:0] RST_OFF_DLY   = CNT_W'(40);
    localparam logic [CNT_W-1:0] RST_ON_DLY    = CNT_W'(100);
    localparam logic [CNT_W-1:0] RST_CLAMP_DLY = CNT_W'(150);

    typedef enum logic [1:0] {
        SEL_OFF   = 2'd0,
        SEL_ON    = 2'd1,
        SEL_CLAMP = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] off_dly;
        logic [CNT_W-1:0] on_dly;
        logic [CNT_W-1:0] clamp_dly;
    } dly_cfg_t;
endpackage

// File: rtl/lht_sync.sv
module lht_sync #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/lht_cfg_regs.sv
module lht_cfg_regs
    import lht_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [1:0]       sel_i,
    input  logic [CNT_W-1:0] data_i,
    output dly_cfg_t         cfg_o
);
    dly_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            unique case (cfg_sel_e'(sel_i))
                SEL_OFF:   cfg_d.off_dly   = data_i;
                SEL_ON:    cfg_d.on_dly    = data_i;
                SEL_CLAMP: cfg_d.clamp_dly = data_i;
                default:   cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q.off_dly   <= RST_OFF_DLY;
            cfg_q.on_dly    <= RST_ON_DLY;
            cfg_q.clamp_dly <= RST_CLAMP_DLY;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    // R10: without a write strobe the stored delays do not move
    assert_cfg_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |=> $stable(cfg_q));
endmodule

// File: rtl/lht_ms_timer.sv
// Counts millisecond ticks while run_i holds; cleared whenever run_i drops.
module lht_ms_timer #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)
            cnt_d = '0;
        else if (tick_i && (cnt_q != CNT_MAX))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign hit_o = run_i && (cnt_q >= limit_i);

    // R6: a running count never wraps back below its previous value
    assert_ms_cnt_no_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && cnt_q != '0) |=> (cnt_q == '0 || cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/lht_hold_timer.sv
// Loads a hold time and counts it down on millisecond ticks.
module lht_hold_timer #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    input  logic         tick_i,
    output logic         busy_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = value_i;
        else if (tick_i && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R4: the hold drains by exactly one per tick
    assert_hold_count_down_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && tick_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/line_handshake_timer.sv
module line_handshake_timer
    import lht_pkg::*;
#(
    parameter int DW = CNT_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          ms_tick_i,
    input  logic          rts_i,
    input  logic          train_done_i,
    input  logic          lvl_above_on_i,
    input  logic          lvl_above_off_i,
    input  logic          hs_done_i,
    input  logic          cfg_we_i,
    input  logic [1:0]    cfg_sel_i,
    input  logic [DW-1:0] cfg_data_i,
    output logic          rfs_o,
    output logic          cd_o,
    output logic          clamp_o
);
    localparam int NSYNC = 4;

    typedef struct packed {
        logic rts_prev;
        logic trained;
        logic rfs;
        logic cd;
        logic clamp;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [NSYNC-1:0] async_in, sync_in;
    logic rts_s, on_s, off_s, hs_s;
    dly_cfg_t cfg;
    logic hold_busy, hold_load;
    logic on_run, off_run, on_hit, off_hit;
    logic clamp_now;

    assign async_in = {hs_done_i, lvl_above_off_i, lvl_above_on_i, rts_i};

    lht_sync #(.W(NSYNC)) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(async_in),
        .sync_o (sync_in)
    );

    assign rts_s = sync_in[0];
    assign on_s  = sync_in[1];
    assign off_s = sync_in[2];
    assign hs_s  = sync_in[3];

    lht_cfg_regs cfg_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .we_i  (cfg_we_i),
        .sel_i (cfg_sel_i),
        .data_i(cfg_data_i),
        .cfg_o (cfg)
    );

    assign hold_load = st_q.rts_prev && !rts_s;

    lht_hold_timer #(.W(DW)) hold_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (hold_load),
        .value_i(cfg.clamp_dly),
        .tick_i (ms_tick_i),
        .busy_o (hold_busy)
    );

    // clamp covers RTS on, the drop cycle itself and the programmed hold
    assign clamp_now = rts_s || st_q.rts_prev || hold_busy;
    assign on_run    = !st_q.cd && on_s && hs_s && !clamp_now;
    assign off_run   = st_q.cd && !off_s;

    lht_ms_timer #(.W(DW)) on_tmr_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (on_run),
        .tick_i (ms_tick_i),
        .limit_i(cfg.on_dly),
        .hit_o  (on_hit)
    );

    lht_ms_timer #(.W(DW)) off_tmr_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (off_run),
        .tick_i (ms_tick_i),
        .limit_i(cfg.off_dly),
        .hit_o  (off_hit)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rts_prev = rts_s;
        st_d.trained  = st_q.trained || (train_done_i && rts_s);
        st_d.rfs      = rts_s && st_d.trained;
        st_d.clamp    = clamp_now;
        if (clamp_now)
            st_d.cd = 1'b0;
        else if (train_done_i)
            st_d.cd = 1'b1;
        else if (st_q.cd && off_hit)
            st_d.cd = 1'b0;
        else if (!st_q.cd && on_hit)
            st_d.cd = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rfs_o   = st_q.rfs;
    assign cd_o    = st_q.cd;
    assign clamp_o = st_q.clamp;

    // R3: carrier detect is never shown while the receive side is clamped
    assert_clamp_masks_cd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.clamp |-> !st_q.cd);

    // R2: ready-for-sending only follows an asserted request-to-send
    assert_rfs_needs_rts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.rfs |-> $past(rts_s));

    // R8: carrier detect rises only through training or an expired ON count
    assert_cd_rise_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.cd) |-> $past(train_done_i || on_hit));
endmodule

// File: tb/line_handshake_timer_tb_top.sv
module line_handshake_timer_tb_top;
    typedef struct packed {
        logic [7:0] off_d;
        logic [7:0] on_d;
        logic [7:0] clamp_d;
    } row_t;

    localparam int NROWS = 3;
    localparam row_t ROWS [NROWS] = '{
        '{off_d: 8'd3, on_d: 8'd5, clamp_d: 8'd2},
        '{off_d: 8'd1, on_d: 8'd2, clamp_d: 8'd1},
        '{off_d: 8'd6, on_d: 8'd4, clamp_d: 8'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0, rts = 1'b0, train = 1'b0;
    logic lvl_on = 1'b0, lvl_off = 1'b0, hs = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_data = 8'd0;
    logic rfs, cd, clamp;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    line_handshake_timer dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .ms_tick_i      (ms_tick),
        .rts_i          (rts),
        .train_done_i   (train),
        .lvl_above_on_i (lvl_on),
        .lvl_above_off_i(lvl_off),
        .hs_done_i      (hs),
        .cfg_we_i       (cfg_we),
        .cfg_sel_i      (cfg_sel),
        .cfg_data_i     (cfg_data),
        .rfs_o          (rfs),
        .cd_o           (cd),
        .clamp_o        (clamp)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            cyc(2);
        end
    endtask

    task automatic pulse_train();
        train = 1'b1;
        @(negedge clk);
        train = 1'b0;
        cyc(3);
    endtask

    task automatic wcfg(input logic [1:0] sel, input logic [7:0] val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_lvl(input logic on_v, input logic off_v);
        lvl_on = on_v; lvl_off = off_v;
        cyc(4);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                finish_run();
            end
        end
    end

    initial begin
        bit seen;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        chk("R1", "rfs after reset", rfs, 1'b0);
        chk("R1", "cd after reset", cd, 1'b0);
        chk("R1", "clamp after reset", clamp, 1'b0);

        // R2/R3: request-to-send before any training
        rts = 1'b1; cyc(4);
        chk("R2", "rfs untrained", rfs, 1'b0);
        chk("R3", "clamp with rts", clamp, 1'b1);
        pulse_train();
        chk("R2", "rfs after training", rfs, 1'b1);
        chk("R3", "training while clamped leaves cd", cd, 1'b0);
        rts = 1'b0; cyc(4);
        chk("R2", "rfs follows rts fall", rfs, 1'b0);
        rts = 1'b1; cyc(4);
        chk("R2", "rfs follows rts rise", rfs, 1'b1);
        rts = 1'b0; cyc(5);
        // R1 default clamp hold of 150 ticks
        ticks(149);
        chk("R1", "default clamp hold at 149", clamp, 1'b1);
        ticks(1);
        chk("R1", "default clamp hold at 150", clamp, 1'b0);

        // R9: level alone before the handshake flag
        set_lvl(1'b1, 1'b1);
        ticks(110);
        chk("R9", "level before handshake", cd, 1'b0);
        // R5: training sets carrier detect
        pulse_train();
        chk("R5", "training sets cd", cd, 1'b1);

        // R1 default OFF delay of 40
        set_lvl(1'b0, 1'b0);
        ticks(39);
        chk("R1", "default off at 39", cd, 1'b1);
        ticks(1);
        chk("R1", "default off at 40", cd, 1'b0);

        // R1 default ON delay of 100
        hs = 1'b1;
        set_lvl(1'b1, 1'b1);
        ticks(99);
        chk("R1", "default on at 99", cd, 1'b0);
        ticks(1);
        chk("R1", "default on at 100", cd, 1'b1);

        // table walk: R10 writes, R6 off, R8 on, R7 cancel, R4 clamp
        for (int r = 0; r < NROWS; r++) begin
            wcfg(2'd0, ROWS[r].off_d);
            wcfg(2'd1, ROWS[r].on_d);
            wcfg(2'd2, ROWS[r].clamp_d);

            set_lvl(1'b0, 1'b0);
            ticks(int'(ROWS[r].off_d) - 1);
            chk("R6", "off one tick early", cd, 1'b1);
            ticks(1);
            chk("R10", "written off delay governs", cd, 1'b0);

            set_lvl(1'b1, 1'b1);
            ticks(int'(ROWS[r].on_d) - 1);
            chk("R8", "on one tick early", cd, 1'b0);
            ticks(1);
            chk("R10", "written on delay governs", cd, 1'b1);

            set_lvl(1'b0, 1'b0);
            ticks(int'(ROWS[r].off_d) - 1);
            set_lvl(1'b0, 1'b1);
            chk("R7", "recovery keeps cd", cd, 1'b1);
            set_lvl(1'b0, 1'b0);
            ticks(int'(ROWS[r].off_d) - 1);
            chk("R7", "count restarted", cd, 1'b1);
            ticks(1);
            chk("R7", "full count after restart", cd, 1'b0);

            set_lvl(1'b0, 1'b1);
            ticks(int'(ROWS[r].on_d) + 2);
            chk("R8", "between thresholds stays off", cd, 1'b0);
            set_lvl(1'b1, 1'b1);
            ticks(int'(ROWS[r].on_d));
            chk("R8", "above on threshold sets cd", cd, 1'b1);

            rts = 1'b1; cyc(4);
            chk("R3", "cd masked by rts", cd, 1'b0);
            chk("R3", "clamp with rts", clamp, 1'b1);
            rts = 1'b0; cyc(5);
            if (ROWS[r].clamp_d == 8'd0) begin
                chk("R4", "zero hold releases", clamp, 1'b0);
            end else begin
                ticks(int'(ROWS[r].clamp_d) - 1);
                chk("R4", "hold one tick early", clamp, 1'b1);
                chk("R4", "cd held off in hold", cd, 1'b0);
                ticks(1);
                chk("R10", "written clamp hold governs", clamp, 1'b0);
            end
            ticks(int'(ROWS[r].on_d));
            chk("R8", "cd back after clamp", cd, 1'b1);
        end

        // coincidence: ON expiry and RTS rise on one edge (cfg on=4 off=6 clamp=0)
        set_lvl(1'b0, 1'b0);
        ticks(6);
        chk("R6", "off before coincidence", cd, 1'b0);
        set_lvl(1'b1, 1'b1);
        ticks(3);
        rts = 1'b1;
        @(negedge clk);
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (cd) seen = 1'b1;
        end
        chk("R3", "clamp wins over on expiry", seen, 1'b0);
        chk("R3", "clamp held at coincidence", clamp, 1'b1);
        pulse_train();
        chk("R3", "training under rts ignored", cd, 1'b0);
        rts = 1'b0; cyc(5);
        chk("R4", "zero hold after coincidence", clamp, 1'b0);
        ticks(3);
        chk("R8", "fresh on count needed", cd, 1'b0);
        ticks(1);
        chk("R8", "on after fresh count", cd, 1'b1);

        finish_run();
    end
endmodule